// File: doc/BRIEF.md
# Block-Write Graphics RAM Datapath

This block models a synchronous, 32-bit-wide graphics memory organised as four 8-bit pixel lanes, one 8-bit-per-pixel pixel per lane. Besides ordinary single-word writes and reads, it offers a block write. One command fills the eight aligned columns of a group from four internal colour registers. Each pixel of each column is enabled by its own bit of the data bus.

Two internal registers shape every write. The colour file holds one 8-bit colour per lane. The bit-plane mask lets individual bit planes be protected. The mask only takes effect for a row that was opened with the special-function flag set. A per-lane byte mask input blocks whole lanes. The pixel enable, the byte mask and the bit-plane mask combine, so a bit is written only when all three allow it. Commands arrive on an opcode input sampled at each rising clock, one command per clock.

Top module: `blkwr_ram`

## Requirements
- R1: After reset, all colour registers are zero, the bit-plane mask is all ones, the special-function flag is clear, and `data_o` and `rvalid_o` are zero.
- R2: LOAD_COLOR (opcode 5) sets colour register i to `data_i[8*i+7:8*i]`, with i from 0 to 3.
- R3: LOAD_MASK (opcode 6) stores `data_i` as the bit-plane mask. In a row opened with the flag high, a mask bit of 1 lets that bit be written and a mask bit of 0 keeps the stored bit.
- R4: In a row opened by ACTIVATE (opcode 1) with `sf_i` low, the bit-plane mask has no effect on writes.
- R5: WRITE (opcode 2) updates only the word at the open row and column `col_i`. The low three column bits pick one of the eight columns in the group.
- R6: BLOCK_WRITE (opcode 3) ignores `col_i[2:0]` and targets all eight columns of the aligned group in the open row.
- R7: During a block write, `data_i[8*i+k]` high writes colour register i into lane i of column k. When that bit is low, the old pixel stays.
- R8: `dqm_i[i]` high during a write or a block write leaves all bits of lane i unchanged in every targeted column.
- R9: Pixel enable, byte mask and bit-plane mask act together. A bit changes only when all three permit it.
- R10: READ (opcode 4) presents the word at the open row and `col_i` on `data_o` after the next rising edge, with `rvalid_o` high for that one cycle. `data_o` holds its value until the next read.
- R11: NOP (opcode 0) and the unused opcode 7 change neither the memory nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command opcode |
| row_i | input | ROW_W | Row address used by ACTIVATE |
| col_i | input | COL_W | Column address |
| sf_i | input | 1 | Special-function flag used by ACTIVATE |
| dqm_i | input | 4 | Per-lane byte mask, 1 blocks the lane |
| data_i | input | 32 | Write data, pixel enables, colour or mask value |
| data_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench goes after column decoding. A write that ignores the low column bits, or a block write that honours them, lands in the wrong word of the group, and a full read-back of the memory shows it. Block writes are swept over many pixel patterns with the byte mask counting through all sixteen values. A swapped lane-to-colour or bit-to-column mapping, or a byte mask that only gates normal writes, therefore corrupts neighbouring pixels. The flag is toggled while a partial mask stays loaded. A design that applies the mask regardless of the flag, or never applies it, damages the protected bit planes or leaves them unwritten. Unused opcodes are sent with noisy data to catch decoders that treat them as writes.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;
  localparam int LANES  = 4;
  localparam int PIX_W  = 8;
  localparam int WORD_W = LANES * PIX_W;
  localparam int GRP_W  = 3;
  localparam int GRP    = 1 << GRP_W;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_WR  = 3'd2,
    OP_BW  = 3'd3,
    OP_RD  = 3'd4,
    OP_LDC = 3'd5,
    OP_LDM = 3'd6
  } op_e;
endpackage

// File: rtl/blkwr_regs.sv
module blkwr_regs import blkwr_pkg::*; #(
  parameter int ROW_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              sf_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] color_o,
  output logic [WORD_W-1:0] mask_o,
  output logic              wpb_o,
  output logic [ROW_W-1:0]  row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      color_o <= '0;
      mask_o  <= '1;
      wpb_o   <= 1'b0;
      row_o   <= '0;
    end else begin
      unique case (op_i)
        OP_ACT: begin
          row_o <= row_i;
          wpb_o <= sf_i;
        end
        OP_LDC:  color_o <= data_i;  // lane i -> colour i
        OP_LDM:  mask_o  <= data_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blkwr_wen.sv
module blkwr_wen import blkwr_pkg::*; (
  input  op_e                           op_i,
  input  logic [GRP_W-1:0]              col_lo_i,
  input  logic [WORD_W-1:0]             data_i,
  input  logic [LANES-1:0]              dqm_i,
  input  logic [WORD_W-1:0]             mask_i,
  input  logic                          wpb_i,
  input  logic [WORD_W-1:0]             color_i,
  output logic [GRP-1:0][WORD_W-1:0]    en_o,
  output logic [GRP-1:0][WORD_W-1:0]    wd_o
);
  logic [WORD_W-1:0] plane_en;
  logic              is_bw, is_wr;

  assign plane_en = wpb_i ? mask_i : '1;
  assign is_bw    = (op_i == OP_BW);
  assign is_wr    = (op_i == OP_WR);

  for (genvar k = 0; k < GRP; k++) begin : g_col
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic pix_on;
      // block write: bus bit per pixel; normal write: decoded column
      assign pix_on = is_bw ? data_i[l*PIX_W + k]
                            : (is_wr && (col_lo_i == GRP_W'(k)));
      assign en_o[k][l*PIX_W +: PIX_W] =
        {PIX_W{pix_on & ~dqm_i[l]}} & plane_en[l*PIX_W +: PIX_W];
      assign wd_o[k][l*PIX_W +: PIX_W] =
        is_bw ? color_i[l*PIX_W +: PIX_W] : data_i[l*PIX_W +: PIX_W];
    end
  end
endmodule

// File: rtl/blkwr_array.sv
module blkwr_array import blkwr_pkg::*; #(
  parameter int GA_W = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [GA_W-1:0]             grp_addr_i,
  input  logic [GRP-1:0][WORD_W-1:0]  en_i,
  input  logic [GRP-1:0][WORD_W-1:0]  wd_i,
  input  logic                        rd_en_i,
  input  logic [GRP_W-1:0]            rd_col_lo_i,
  output logic [WORD_W-1:0]           data_o,
  output logic                        rvalid_o
);
  localparam int DEPTH = 1 << (GA_W + GRP_W);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < GRP; k++) begin
      mem_q[{grp_addr_i, GRP_W'(k)}] <=
        (mem_q[{grp_addr_i, GRP_W'(k)}] & ~en_i[k]) | (wd_i[k] & en_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) data_o <= mem_q[{grp_addr_i, rd_col_lo_i}];
    end
  end
endmodule

// File: rtl/blkwr_ram.sv
module blkwr_ram import blkwr_pkg::*; #(
  parameter int ROWS = 16,
  parameter int COLS = 64,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              sf_i,
  input  logic [LANES-1:0]  dqm_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              rvalid_o
);
  localparam int GA_W = ROW_W + COL_W - GRP_W;

  op_e                        op;
  logic [WORD_W-1:0]          color_q, mask_q;
  logic                       wpb_q;
  logic [ROW_W-1:0]           row_q;
  logic [GRP-1:0][WORD_W-1:0] wr_en, wr_data;

  assign op = op_e'(cmd_i);

  blkwr_regs #(.ROW_W(ROW_W)) i_regs (
    .clk_i, .rst_ni, .op_i(op), .row_i, .sf_i, .data_i,
    .color_o(color_q), .mask_o(mask_q), .wpb_o(wpb_q), .row_o(row_q)
  );

  blkwr_wen i_wen (
    .op_i(op), .col_lo_i(col_i[GRP_W-1:0]), .data_i, .dqm_i,
    .mask_i(mask_q), .wpb_i(wpb_q), .color_i(color_q),
    .en_o(wr_en), .wd_o(wr_data)
  );

  blkwr_array #(.GA_W(GA_W)) i_array (
    .clk_i, .rst_ni,
    .grp_addr_i({row_q, col_i[COL_W-1:GRP_W]}),
    .en_i(wr_en), .wd_i(wr_data),
    .rd_en_i(op == OP_RD), .rd_col_lo_i(col_i[GRP_W-1:0]),
    .data_o, .rvalid_o
  );
endmodule

// File: rtl/blkwr_chk.sv
module blkwr_chk import blkwr_pkg::*; (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [2:0]                 cmd_i,
  input logic [WORD_W-1:0]          data_i,
  input logic                       sf_i,
  input logic [LANES-1:0]           dqm_i,
  input logic [GRP_W-1:0]           col_lo_i,
  input logic [WORD_W-1:0]          color_i,
  input logic [WORD_W-1:0]          mask_i,
  input logic                       wpb_i,
  input logic [GRP-1:0][WORD_W-1:0] wr_en_i,
  input logic                       rvalid_i
);
  // R2
  color_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == OP_LDC |=> color_i == $past(data_i));

  // R3
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == OP_LDM |=> mask_i == $past(data_i));

  // R4
  flag_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == OP_ACT |=> wpb_i == $past(sf_i));

  // R4
  flag_off_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == OP_WR && !wpb_i && dqm_i == '0) |-> wr_en_i[col_lo_i] == '1);

  // R8
  all_lanes_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == OP_WR || cmd_i == OP_BW) && dqm_i == '1) |-> wr_en_i == '0);

  // R11
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != OP_WR && cmd_i != OP_BW) |-> wr_en_i == '0);

  // R10
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == OP_RD |=> rvalid_i);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i != OP_RD |=> !rvalid_i);
endmodule

bind blkwr_ram blkwr_chk i_chk (
  .clk_i, .rst_ni, .cmd_i, .data_i, .sf_i, .dqm_i,
  .col_lo_i(col_i[2:0]), .color_i(color_q), .mask_i(mask_q),
  .wpb_i(wpb_q), .wr_en_i(wr_en), .rvalid_i(rvalid_o)
);

// File: tb/test_blkwr_ram.sv
`timescale 1ns/1ps
module test_blkwr_ram;
  import blkwr_pkg::*;

  localparam int ROWS  = 4;
  localparam int COLS  = 16;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        cmd_i = OP_NOP;
  logic [ROW_W-1:0]  row_i = '0;
  logic [COL_W-1:0]  col_i = '0;
  logic              sf_i = 1'b0;
  logic [3:0]        dqm_i = '0;
  logic [31:0]       data_i = '0;
  logic [31:0]       data_o;
  logic              rvalid_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mdl [ROWS*COLS];
  logic [31:0] m_color = '0;
  logic [31:0] m_mask = '1;
  logic        m_wpb = 1'b0;
  int          m_row = 0;

  always #4 clk_i = ~clk_i;

  blkwr_ram #(.ROWS(ROWS), .COLS(COLS)) i_blkwr_ram (
    .clk_i, .rst_ni, .cmd_i, .row_i, .col_i, .sf_i, .dqm_i, .data_i,
    .data_o, .rvalid_o
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] lane_en(input logic [3:0] dqm);
    logic [31:0] m = '0;
    for (int l = 0; l < 4; l++) if (!dqm[l]) m[8*l +: 8] = 8'hFF;
    return m;
  endfunction

  // drive at negedge, sampled at the following posedge; model updated there
  task automatic cmd(input logic [2:0] op, input int r, input int c,
                     input logic sf, input logic [3:0] dqm, input logic [31:0] d);
    logic [31:0] pl, en, px;
    int base;
    cmd_i = op; row_i = ROW_W'(r); col_i = COL_W'(c);
    sf_i = sf; dqm_i = dqm; data_i = d;
    @(posedge clk_i);
    pl = m_wpb ? m_mask : '1;
    case (op)
      OP_ACT: begin m_row = r; m_wpb = sf; end
      OP_LDC: m_color = d;
      OP_LDM: m_mask = d;
      OP_WR: begin
        en = lane_en(dqm) & pl;
        mdl[m_row*COLS + c] = (mdl[m_row*COLS + c] & ~en) | (d & en);
      end
      OP_BW: begin
        base = m_row*COLS + (c / 8) * 8;
        for (int k = 0; k < 8; k++) begin
          px = '0;
          for (int l = 0; l < 4; l++) if (d[8*l + k]) px[8*l +: 8] = 8'hFF;
          en = px & lane_en(dqm) & pl;
          mdl[base + k] = (mdl[base + k] & ~en) | (m_color & en);
        end
      end
      default: ;
    endcase
    @(negedge clk_i);
    cmd_i = OP_NOP; data_i = 32'hDEAD_BEEF; dqm_i = 4'h5; col_i = '0;
  endtask

  task automatic verify_all(input string req);
    logic keep_wpb;
    keep_wpb = m_wpb;
    for (int r = 0; r < ROWS; r++) begin
      cmd(OP_ACT, r, 0, 1'b0, 4'h0, '0);
      for (int c = 0; c < COLS; c++) begin
        cmd(OP_RD, 0, c, 1'b0, 4'h0, '0);
        chk(req, data_o, mdl[r*COLS + c]);
        chk("R10 rvalid", {31'b0, rvalid_o}, 32'd1);
      end
    end
    cmd(OP_NOP, 0, 0, 1'b0, 4'h0, '0);
    chk("R10 rvalid drop", {31'b0, rvalid_o}, 32'd0);
    m_wpb = keep_wpb;
  endtask

  function automatic logic [31:0] hsh(input int a, input int b);
    return (32'(a) * 32'h9E37_79B1) ^ (32'(b) * 32'h85EB_CA6B) ^ 32'h1234_5678;
  endfunction

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1 outputs in reset
    chk("R1 data_o", data_o, '0);
    chk("R1 rvalid_o", {31'b0, rvalid_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 fill every word with normal writes, flag low
    for (int r = 0; r < ROWS; r++) begin
      cmd(OP_ACT, r, 0, 1'b0, 4'h0, '0);
      for (int c = 0; c < COLS; c++) cmd(OP_WR, 0, c, 1'b0, 4'h0, hsh(r, c));
    end
    verify_all("R5 fill");

    // R8 normal writes under every byte mask
    for (int r = 0; r < ROWS; r++) begin
      cmd(OP_ACT, r, 0, 1'b0, 4'h0, '0);
      for (int c = 0; c < COLS; c++) cmd(OP_WR, 0, c, 1'b0, 4'(c), ~hsh(c, r));
    end
    verify_all("R8 write dqm");

    // R1 reset colours zero, mask all ones: block write with flag high
    cmd(OP_ACT, 1, 0, 1'b1, 4'h0, '0);
    cmd(OP_BW, 0, 13, 1'b0, 4'h0, 32'hFFFF_FFFF);
    verify_all("R1 reset colour/mask");

    // R2 R6 R7 R8 block write sweep, flag low
    cmd(OP_LDC, 0, 0, 1'b0, 4'h0, 32'hC3E1_0FA3);
    for (int p = 0; p < 32; p++) begin
      cmd(OP_ACT, p % ROWS, 0, 1'b0, 4'h0, '0);
      cmd(OP_BW, 0, (p * 5) % COLS, 1'b0, 4'(p), hsh(p, 7));
    end
    verify_all("R7 block write sweep");
    cmd(OP_LDC, 0, 0, 1'b0, 4'h0, 32'h1122_8844);
    for (int p = 0; p < 8; p++) begin
      cmd(OP_ACT, p % ROWS, 0, 1'b0, 4'h0, '0);
      cmd(OP_BW, 0, 8 + p, 1'b0, 4'h0, 32'h01 << p);
    end
    verify_all("R2 R6 lane/column mapping");

    // R3 R9 partial mask, flag high
    cmd(OP_LDM, 0, 0, 1'b0, 4'h0, 32'hFFDD_4276);
    for (int r = 0; r < ROWS; r++) begin
      cmd(OP_ACT, r, 0, 1'b1, 4'h0, '0);
      for (int c = 0; c < COLS; c += 3) cmd(OP_WR, 0, c, 1'b0, 4'(c), hsh(c, 99));
      cmd(OP_BW, 0, 2, 1'b0, 4'(r), 32'h7777_FF55);
      cmd(OP_BW, 0, 9, 1'b0, 4'h1, hsh(r, 3));
    end
    verify_all("R9 combined masks");

    // R4 mask stays loaded, flag low
    for (int r = 0; r < ROWS; r++) begin
      cmd(OP_ACT, r, 0, 1'b0, 4'h0, '0);
      cmd(OP_WR, 0, r * 3, 1'b0, 4'h0, hsh(r, 55));
      cmd(OP_BW, 0, 8, 1'b0, 4'h0, 32'hA5A5_A5A5);
    end
    verify_all("R4 mask ignored");

    // R11 idle opcodes with noisy data change nothing
    cmd(OP_ACT, 2, 0, 1'b0, 4'h0, '0);
    for (int c = 0; c < COLS; c++) begin
      cmd(3'd7, 0, c, 1'b1, 4'h0, 32'hFFFF_FFFF);
      cmd(OP_NOP, 0, c, 1'b1, 4'h0, 32'hFFFF_FFFF);
    end
    cmd(OP_BW, 0, 0, 1'b0, 4'h0, 32'hFFFF_FFFF);  // colours unchanged
    verify_all("R11 idle opcodes");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule